// File: doc/BRIEF.md
# Segmented Physical Address Generator

This unit forms the byte address for every memory access of a 16-bit processor that uses segmented memory. For each request it works out a 16-bit offset, called the effective address, from the pointer and index registers and a displacement. It picks one of four 16-bit segment registers and combines the two into a 20-bit physical address. The segment value is multiplied by 16 before the offset is added.

The caller presents the register values together with an access type on the same cycle as `req_i`. The access type is one of: instruction fetch, data operand, word push, string source or string destination. For data operands the caller also gives an addressing mode and a displacement. The effective address, the chosen segment and the physical address appear on registered outputs one clock later, flagged by `valid_o`. The default segment follows from the base register and the access type. An optional override can replace the segment for data and string-source accesses only. Decoding, register writes and the bus cycle sit outside this block.

Top module: `seg_addr_gen`

## Requirements
- R1: `valid_o` is 1 in the cycle after a clock edge that sampled `req_i`=1, and 0 after an edge that sampled `req_i`=0. While `rst_n`=0, `valid_o`, `ea_o`, `seg_o` and `pa_o` are all cleared to 0.
- R2: `pa_o` = (segment value × 16 + `ea_o`) mod 2^20. Examples: segment 2A40h with offset AAAAh gives 34EAAh, and segment FFFFh with offset 0010h wraps to 00000h.
- R3: Access type 0 (fetch) uses the code segment (`seg_o`=1) with `ip_i` as offset. The override inputs have no effect on a fetch.
- R4: Access type 1 (data) with `mode_i`=0 (direct) takes the displacement alone as the offset and uses the data segment (`seg_o`=3).
- R5: Data with `mode_i`=1 (register indirect) takes the offset from one register, picked by `rsel_i`: 0=BX, 1=BP, 2=SI, 3=DI. BP selects the stack segment (`seg_o`=2); the other three select the data segment.
- R6: Data with `mode_i`=2 or 3 (based-indexed) forms the offset as (base + index + displacement) mod 2^16. `base_bp_i` picks the base (0=BX, 1=BP) and `idx_di_i` picks the index (0=SI, 1=DI). A BP base defaults to the stack segment and a BX base to the data segment.
- R7: When `disp_wide_i`=0, only `disp_i[7:0]` is used, sign-extended to 16 bits, and `disp_i[15:8]` has no effect. When `disp_wide_i`=1, all 16 bits are used.
- R8: Access type 2 (push) uses the stack segment with offset (`sp_i` − 2) mod 2^16. This is the low-byte address of the pushed word; the high byte goes one above it.
- R9: Access type 3 (string source) uses the data segment with `si_i`. Access type 4 (string destination) uses the extra segment (`seg_o`=0) with `di_i`, and the override has no effect on it.
- R10: With `ovr_en_i`=1, a data or string-source access uses segment `ovr_seg_i` instead of its default. The segment code is 0=ES, 1=CS, 2=SS, 3=DS, and `seg_o` uses the same code. Fetch, push and string-destination accesses ignore the override.
- R11: After an edge that sampled `req_i`=0, `ea_o`, `seg_o` and `pa_o` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_i | input | 1 | Request strobe; all other inputs are sampled with it |
| acc_i | input | 3 | Access type: 0 fetch, 1 data, 2 push, 3 string source, 4 string destination |
| mode_i | input | 2 | Data addressing mode: 0 direct, 1 register indirect, 2/3 based-indexed |
| rsel_i | input | 2 | Register for indirect mode: 0 BX, 1 BP, 2 SI, 3 DI |
| base_bp_i | input | 1 | Based-indexed base: 0 BX, 1 BP |
| idx_di_i | input | 1 | Based-indexed index: 0 SI, 1 DI |
| disp_wide_i | input | 1 | 1: 16-bit displacement; 0: sign-extended 8-bit |
| disp_i | input | 16 | Displacement |
| ovr_en_i | input | 1 | Segment override enable |
| ovr_seg_i | input | 2 | Override segment code (0 ES, 1 CS, 2 SS, 3 DS) |
| es_i | input | 16 | Extra segment value |
| cs_i | input | 16 | Code segment value |
| ss_i | input | 16 | Stack segment value |
| ds_i | input | 16 | Data segment value |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| sp_i | input | 16 | Stack pointer value |
| ip_i | input | 16 | Instruction pointer value |
| valid_o | output | 1 | Outputs hold a new result |
| ea_o | output | 16 | Effective address |
| seg_o | output | 2 | Chosen segment code |
| pa_o | output | 20 | Physical address |

## Verification
The assertions assume that every input is a known value whenever `req_i` is high. They also assume that `acc_i` stays within the five defined types, since the default-segment checks only constrain those codes. The stimulus never drives `acc_i` above 4 and drives every field on every cycle, including cycles where `req_i` is low. On those cycles the other inputs change freely, so the hold behaviour is tested against moving inputs. Random register values push the offset and physical sums across both wrap boundaries. Random override settings are paired with every access type, so that the ignored cases are exercised as often as the applied ones.

// File: rtl/seg_addr_pkg.sv
// Package: shared encodings for the segmented address generator.
// Assumes: segment codes match the seg_o port encoding.
package seg_addr_pkg;

    typedef enum logic [2:0] {
        ACC_FETCH   = 3'd0,
        ACC_DATA    = 3'd1,
        ACC_PUSH    = 3'd2,
        ACC_STR_SRC = 3'd3,
        ACC_STR_DST = 3'd4
    } acc_e;

    typedef enum logic [1:0] {
        SEG_ES = 2'd0,
        SEG_CS = 2'd1,
        SEG_SS = 2'd2,
        SEG_DS = 2'd3
    } seg_e;

    typedef enum logic [1:0] {
        RS_BX = 2'd0,
        RS_BP = 2'd1,
        RS_SI = 2'd2,
        RS_DI = 2'd3
    } rsel_e;

    localparam logic [1:0] MODE_DIRECT   = 2'd0;
    localparam logic [1:0] MODE_INDIRECT = 2'd1;

endpackage

// File: rtl/seg_ea_calc.sv
// Module: seg_ea_calc
// Forms the effective address for one access and reports whether BP
// took part as the base (used by the segment chooser).
// Assumes: inputs are stable while sampled; sums wrap at OFS_W bits.
module seg_ea_calc
    import seg_addr_pkg::*;
#(
    parameter int OFS_W       = 16,
    parameter int DISP_S_W    = 8,
    parameter int PUSH_BYTES  = 2
) (
    input  acc_e             acc,
    input  logic [1:0]       mode,
    input  rsel_e            rsel,
    input  logic             base_bp,
    input  logic             idx_di,
    input  logic             disp_wide,
    input  logic [OFS_W-1:0] disp,
    input  logic [OFS_W-1:0] bx,
    input  logic [OFS_W-1:0] bp,
    input  logic [OFS_W-1:0] si,
    input  logic [OFS_W-1:0] di,
    input  logic [OFS_W-1:0] sp,
    input  logic [OFS_W-1:0] ip,
    output logic [OFS_W-1:0] ea,
    output logic             uses_bp
);

    localparam int EXT_W = OFS_W - DISP_S_W;
    localparam logic [OFS_W-1:0] PUSH_DEC = OFS_W'(PUSH_BYTES);

    logic [OFS_W-1:0] disp_ext;
    logic [OFS_W-1:0] base_val;
    logic [OFS_W-1:0] idx_val;
    logic [OFS_W-1:0] ind_val;

    // Purpose: widen the short displacement by sign extension.
    always_comb begin
        if (disp_wide) disp_ext = disp;
        else           disp_ext = {{EXT_W{disp[DISP_S_W-1]}}, disp[DISP_S_W-1:0]};
    end

    // Purpose: pick base, index and single indirect register.
    always_comb begin
        base_val = base_bp ? bp : bx;
        idx_val  = idx_di  ? di : si;
        case (rsel)
            RS_BX:   ind_val = bx;
            RS_BP:   ind_val = bp;
            RS_SI:   ind_val = si;
            default: ind_val = di;
        endcase
    end

    // Purpose: choose the offset source by access type and mode.
    always_comb begin
        uses_bp = 1'b0;
        case (acc)
            ACC_FETCH:   ea = ip;
            ACC_PUSH:    ea = sp - PUSH_DEC;
            ACC_STR_SRC: ea = si;
            ACC_STR_DST: ea = di;
            default: begin
                if (mode == MODE_DIRECT) begin
                    ea = disp_ext;
                end else if (mode == MODE_INDIRECT) begin
                    ea      = ind_val;
                    uses_bp = (rsel == RS_BP);
                end else begin
                    ea      = base_val + idx_val + disp_ext;
                    uses_bp = base_bp;
                end
            end
        endcase
    end

endmodule

// File: rtl/seg_select.sv
// Module: seg_select
// Chooses the segment for an access: a fixed segment for fetch, push and
// string destination; the stack or data segment for operands, by base
// register; an override replaces it for data and string-source accesses.
// Assumes: segment code encoding from seg_addr_pkg.
module seg_select
    import seg_addr_pkg::*;
#(
    parameter int SEG_W = 16,
    parameter int N_SEG = 4
) (
    input  acc_e             acc,
    input  logic             uses_bp,
    input  logic             ovr_en,
    input  seg_e             ovr_seg,
    input  logic [SEG_W-1:0] seg_vals [N_SEG],
    output seg_e             seg_sel,
    output logic [SEG_W-1:0] seg_val
);

    seg_e dflt;
    logic ovr_ok;

    // Purpose: default segment from access type and base register.
    always_comb begin
        ovr_ok = 1'b0;
        case (acc)
            ACC_FETCH:   dflt = SEG_CS;
            ACC_PUSH:    dflt = SEG_SS;
            ACC_STR_DST: dflt = SEG_ES;
            ACC_STR_SRC: begin
                dflt   = SEG_DS;
                ovr_ok = 1'b1;
            end
            default: begin
                dflt   = uses_bp ? SEG_SS : SEG_DS;
                ovr_ok = 1'b1;
            end
        endcase
    end

    // Purpose: apply the override where permitted and fetch the value.
    always_comb begin
        seg_sel = (ovr_ok && ovr_en) ? ovr_seg : dflt;
        seg_val = seg_vals[seg_sel];
    end

endmodule

// File: rtl/seg_pa_adder.sv
// Module: seg_pa_adder
// Shifts the segment value left by SHIFT bits and adds the offset.
// Assumes: result wraps at PA_W bits.
module seg_pa_adder #(
    parameter int SEG_W = 16,
    parameter int OFS_W = 16,
    parameter int SHIFT = 4,
    parameter int PA_W  = SEG_W + SHIFT
) (
    input  logic [SEG_W-1:0] seg_val,
    input  logic [OFS_W-1:0] ofs,
    output logic [PA_W-1:0]  pa
);

    // Purpose: segment*2^SHIFT + offset, modulo 2^PA_W.
    always_comb begin
        pa = PA_W'({seg_val, {SHIFT{1'b0}}}) + PA_W'(ofs);
    end

endmodule

// File: rtl/seg_addr_gen.sv
// Module: seg_addr_gen (top)
// Registers the effective address, segment code and physical address one
// clock after a request; outputs hold while no request is present.
// Assumes: all inputs valid when req_i is high; acc_i within 0..4.
module seg_addr_gen
    import seg_addr_pkg::*;
#(
    parameter int OFS_W    = 16,
    parameter int SEG_W    = 16,
    parameter int SHIFT    = 4,
    parameter int DISP_S_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_i,
    input  logic [2:0]             acc_i,
    input  logic [1:0]             mode_i,
    input  logic [1:0]             rsel_i,
    input  logic                   base_bp_i,
    input  logic                   idx_di_i,
    input  logic                   disp_wide_i,
    input  logic [OFS_W-1:0]       disp_i,
    input  logic                   ovr_en_i,
    input  logic [1:0]             ovr_seg_i,
    input  logic [SEG_W-1:0]       es_i,
    input  logic [SEG_W-1:0]       cs_i,
    input  logic [SEG_W-1:0]       ss_i,
    input  logic [SEG_W-1:0]       ds_i,
    input  logic [OFS_W-1:0]       bx_i,
    input  logic [OFS_W-1:0]       bp_i,
    input  logic [OFS_W-1:0]       si_i,
    input  logic [OFS_W-1:0]       di_i,
    input  logic [OFS_W-1:0]       sp_i,
    input  logic [OFS_W-1:0]       ip_i,
    output logic                   valid_o,
    output logic [OFS_W-1:0]       ea_o,
    output logic [1:0]             seg_o,
    output logic [SEG_W+SHIFT-1:0] pa_o
);

    localparam int PA_W  = SEG_W + SHIFT;
    localparam int N_SEG = 4;

    acc_e             acc;
    logic [OFS_W-1:0] ea_c;
    logic             uses_bp;
    seg_e             seg_c;
    logic [SEG_W-1:0] seg_val_c;
    logic [PA_W-1:0]  pa_c;
    logic [SEG_W-1:0] seg_vals [N_SEG];

    assign acc = acc_e'(acc_i);

    // Purpose: gather segment values indexed by segment code.
    always_comb begin
        seg_vals[SEG_ES] = es_i;
        seg_vals[SEG_CS] = cs_i;
        seg_vals[SEG_SS] = ss_i;
        seg_vals[SEG_DS] = ds_i;
    end

    seg_ea_calc #(.OFS_W(OFS_W), .DISP_S_W(DISP_S_W), .PUSH_BYTES(2)) u_ea (
        .acc(acc), .mode(mode_i), .rsel(rsel_e'(rsel_i)), .base_bp(base_bp_i),
        .idx_di(idx_di_i), .disp_wide(disp_wide_i), .disp(disp_i),
        .bx(bx_i), .bp(bp_i), .si(si_i), .di(di_i), .sp(sp_i), .ip(ip_i),
        .ea(ea_c), .uses_bp(uses_bp)
    );

    seg_select #(.SEG_W(SEG_W), .N_SEG(N_SEG)) u_seg (
        .acc(acc), .uses_bp(uses_bp), .ovr_en(ovr_en_i),
        .ovr_seg(seg_e'(ovr_seg_i)), .seg_vals(seg_vals),
        .seg_sel(seg_c), .seg_val(seg_val_c)
    );

    seg_pa_adder #(.SEG_W(SEG_W), .OFS_W(OFS_W), .SHIFT(SHIFT), .PA_W(PA_W)) u_pa (
        .seg_val(seg_val_c), .ofs(ea_c), .pa(pa_c)
    );

    // Purpose: output register stage, loaded only on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            ea_o    <= '0;
            seg_o   <= '0;
            pa_o    <= '0;
        end else begin
            valid_o <= req_i;
            if (req_i) begin
                ea_o  <= ea_c;
                seg_o <= seg_c;
                pa_o  <= pa_c;
            end
        end
    end

    AST_VALID_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_i |=> valid_o); // R1
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !valid_o); // R1
    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> ($stable(ea_o) && $stable(pa_o) && $stable(seg_o))); // R11
    AST_FETCH_CODE_SEG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && acc_i == ACC_FETCH) |=> (seg_o == SEG_CS && ea_o == $past(ip_i))); // R3
    AST_PUSH_STACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && acc_i == ACC_PUSH) |=> (seg_o == SEG_SS && ea_o == OFS_W'($past(sp_i) - OFS_W'(2)))); // R8
    AST_DST_EXTRA: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && acc_i == ACC_STR_DST) |=> (seg_o == SEG_ES && ea_o == $past(di_i))); // R9
    AST_BP_STACK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && acc_i == ACC_DATA && !ovr_en_i && mode_i[1] && base_bp_i) |=> (seg_o == SEG_SS)); // R6
    AST_OVR_APPLIED: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && acc_i == ACC_DATA && ovr_en_i) |=> (seg_o == $past(ovr_seg_i))); // R10

endmodule

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic [2:0]  acc_i = '0;
    logic [1:0]  mode_i = '0, rsel_i = '0, ovr_seg_i = '0;
    logic        base_bp_i = 1'b0, idx_di_i = 1'b0, disp_wide_i = 1'b0, ovr_en_i = 1'b0;
    logic [15:0] disp_i = '0;
    logic [15:0] es_i = '0, cs_i = '0, ss_i = '0, ds_i = '0;
    logic [15:0] bx_i = '0, bp_i = '0, si_i = '0, di_i = '0, sp_i = '0, ip_i = '0;
    logic        valid_o;
    logic [15:0] ea_o;
    logic [1:0]  seg_o;
    logic [19:0] pa_o;

    int n_tests = 0;
    int n_fail  = 0;
    int exp_ea = 0, exp_seg = 0, exp_pa = 0;
    bit exp_v = 1'b0;
    string exp_tag = "R1";

    always #4 clk = ~clk;

    seg_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .acc_i(acc_i), .mode_i(mode_i),
        .rsel_i(rsel_i), .base_bp_i(base_bp_i), .idx_di_i(idx_di_i),
        .disp_wide_i(disp_wide_i), .disp_i(disp_i), .ovr_en_i(ovr_en_i),
        .ovr_seg_i(ovr_seg_i), .es_i(es_i), .cs_i(cs_i), .ss_i(ss_i), .ds_i(ds_i),
        .bx_i(bx_i), .bp_i(bp_i), .si_i(si_i), .di_i(di_i), .sp_i(sp_i), .ip_i(ip_i),
        .valid_o(valid_o), .ea_o(ea_o), .seg_o(seg_o), .pa_o(pa_o)
    );

    // Reference model from the requirements (segment codes 0 ES,1 CS,2 SS,3 DS).
    task automatic model(output int m_ea, output int m_seg, output int m_pa, output string tag);
        int d, segv, base, idx;
        bit can_ovr;
        can_ovr = 0;
        d = disp_wide_i ? int'(disp_i) : ((int'(disp_i[7:0]) ^ 128) - 128);
        case (acc_i)
            3'd0: begin m_ea = ip_i; m_seg = 1; tag = "R3"; end
            3'd2: begin m_ea = (int'(sp_i) - 2) & 'hFFFF; m_seg = 2; tag = "R8"; end
            3'd3: begin m_ea = si_i; m_seg = 3; can_ovr = 1; tag = "R9"; end
            3'd4: begin m_ea = di_i; m_seg = 0; tag = "R9"; end
            default: begin
                can_ovr = 1;
                if (mode_i == 0) begin
                    m_ea = d & 'hFFFF; m_seg = 3; tag = disp_wide_i ? "R4" : "R4/R7";
                end else if (mode_i == 1) begin
                    case (rsel_i)
                        2'd0: m_ea = bx_i;
                        2'd1: m_ea = bp_i;
                        2'd2: m_ea = si_i;
                        default: m_ea = di_i;
                    endcase
                    m_seg = (rsel_i == 1) ? 2 : 3; tag = "R5";
                end else begin
                    base = base_bp_i ? int'(bp_i) : int'(bx_i);
                    idx  = idx_di_i ? int'(di_i) : int'(si_i);
                    m_ea = (base + idx + d) & 'hFFFF;
                    m_seg = base_bp_i ? 2 : 3; tag = disp_wide_i ? "R6" : "R6/R7";
                end
            end
        endcase
        if (can_ovr && ovr_en_i) begin m_seg = ovr_seg_i; tag = {tag, "/R10"}; end
        else if (ovr_en_i) tag = {tag, "/R10"};
        case (m_seg)
            0: segv = es_i;
            1: segv = cs_i;
            2: segv = ss_i;
            default: segv = ds_i;
        endcase
        m_pa = ((segv << 4) + m_ea) & 'hFFFFF;
        tag = {"R2/", tag};
    endtask

    task automatic check_outputs();
        n_tests++;
        if (valid_o !== exp_v || ea_o !== 16'(exp_ea) || seg_o !== 2'(exp_seg) || pa_o !== 20'(exp_pa)) begin
            n_fail++;
            $display("FAIL %s: actual v=%0b ea=%h seg=%0d pa=%h expected v=%0b ea=%h seg=%0d pa=%h",
                     exp_tag, valid_o, ea_o, seg_o, pa_o, exp_v, 16'(exp_ea), exp_seg, 20'(exp_pa));
        end
    endtask

    // One clock: compute expectation from the inputs now driven, then compare.
    task automatic run_cycle();
        if (req_i) begin
            model(exp_ea, exp_seg, exp_pa, exp_tag);
            exp_v = 1'b1;
        end else begin
            exp_v = 1'b0;
            exp_tag = "R1/R11";
        end
        @(negedge clk);
        check_outputs();
    endtask

    task automatic check_pa(input logic [19:0] want, input string tag);
        n_tests++;
        if (pa_o !== want) begin
            n_fail++;
            $display("FAIL %s: actual pa=%h expected pa=%h", tag, pa_o, want);
        end
    endtask

    task automatic randomize_inputs();
        req_i = 1'($urandom_range(0, 3) != 0);
        acc_i = 3'($urandom_range(0, 4));
        mode_i = 2'($urandom); rsel_i = 2'($urandom); ovr_seg_i = 2'($urandom);
        base_bp_i = 1'($urandom); idx_di_i = 1'($urandom);
        disp_wide_i = 1'($urandom); ovr_en_i = 1'($urandom);
        disp_i = 16'($urandom);
        es_i = 16'($urandom); cs_i = 16'($urandom); ss_i = 16'($urandom); ds_i = 16'($urandom);
        bx_i = 16'($urandom); bp_i = 16'($urandom); si_i = 16'($urandom);
        di_i = 16'($urandom); sp_i = 16'($urandom); ip_i = 16'($urandom);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual=timeout expected=finished");
        summary();
        $finish;
    end

    initial begin
        // R1: reset state
        req_i = 1'b1; acc_i = 3'd0; ip_i = 16'h1234; cs_i = 16'h5555;
        repeat (3) @(negedge clk);
        exp_v = 0; exp_ea = 0; exp_seg = 0; exp_pa = 0; exp_tag = "R1 reset";
        check_outputs();
        req_i = 1'b0;
        rst_n = 1'b1;
        run_cycle();

        // R2/R3: fetch 2A40:AAAA, override must be ignored
        req_i = 1; acc_i = 0; cs_i = 16'h2A40; ip_i = 16'hAAAA;
        ovr_en_i = 1; ovr_seg_i = 2'd3; ds_i = 16'h0100;
        run_cycle(); check_pa(20'h34EAA, "R2/R3 example");

        // R5: indirect BX with DS 5D66, offset BCDE
        acc_i = 1; mode_i = 1; rsel_i = 0; ovr_en_i = 0; ds_i = 16'h5D66; bx_i = 16'hBCDE;
        run_cycle(); check_pa(20'h6933E, "R2/R5 example");
        // R5: indirect BP defaults to stack
        rsel_i = 1; bp_i = 16'h0042; ss_i = 16'h3000;
        run_cycle();

        // R6/R7: BP+DI with negative short disp and junk upper bits
        mode_i = 2; base_bp_i = 1; idx_di_i = 1; di_i = 16'h0010;
        disp_wide_i = 0; disp_i = 16'hA580;
        run_cycle();
        // R6: BX+SI+disp16 wraps past FFFF
        base_bp_i = 0; idx_di_i = 0; bx_i = 16'hFFFF; si_i = 16'h0002;
        disp_wide_i = 1; disp_i = 16'h0001;
        run_cycle();
        // R4: direct mode
        mode_i = 0; disp_i = 16'h8001;
        run_cycle();

        // R8: push with SP=0001 wraps
        acc_i = 2; sp_i = 16'h0001; ovr_en_i = 1; ovr_seg_i = 2'd0;
        run_cycle();
        // R9/R10: string source overridden to ES, destination ignores override
        acc_i = 3; si_i = 16'h0F0F; es_i = 16'h7000;
        run_cycle();
        acc_i = 4; di_i = 16'hF0F0; ovr_seg_i = 2'd3;
        run_cycle();

        // R2: physical wrap FFFF:0010 -> 00000
        acc_i = 0; ovr_en_i = 0; cs_i = 16'hFFFF; ip_i = 16'h0010;
        run_cycle(); check_pa(20'h00000, "R2 wrap");

        // R11: idle with moving inputs
        for (int i = 0; i < 4; i++) begin
            req_i = 0; cs_i = 16'($urandom); ip_i = 16'($urandom);
            run_cycle();
        end

        // Random traffic across all access types
        for (int i = 0; i < 2000; i++) begin
            randomize_inputs();
            run_cycle();
        end

        summary();
        $finish;
    end

endmodule